// File: doc/BRIEF.md
# Dual Issue Queue with Replay

This block schedules instructions out of two queues. The main queue holds dispatched instructions that have not issued yet. An entry becomes ready when its source operand is marked ready at dispatch, or when a wakeup broadcast carries a matching tag. Each cycle the ready entries bid, and an age-ordered selector grants up to `ISSUE_W` of them to the issue ports. A granted entry leaves the main queue at once, so its slot is free for new dispatch.

A wakeup that comes from a load is speculative, because the load is assumed to hit. That wakeup opens a speculative window tagged with the load. Every instruction that issues from the main queue while the window is open is copied into a small replay queue. The copy records whether it depends directly on the load. When the load resolves as a hit, its copies are dropped. When it resolves as a miss, the copies selected by the replay policy are re-issued. Replay re-issues take the issue slots ahead of main-queue entries. The replay policy is latched on the first clock after reset.

Top module: `dual_issue_queue`

## Requirements
- R1: After reset no issue port is valid and `disp_ready_o` is 1.
- R2: A dispatch is accepted while the main queue has a free entry. With all `MIQ_N` entries occupied, `disp_ready_o` is 0 and a dispatch attempt is dropped.
- R3: An entry is eligible from the cycle after it is dispatched with `disp_src_rdy_i`=1, or from the cycle after a wakeup whose tag equals its source tag. An eligible entry that is not held back appears on an issue port in that cycle.
- R4: At most `ISSUE_W` instructions issue per cycle, oldest dispatch first. The oldest goes on port 0, and the valid ports are always the lowest-numbered ones.
- R5: An issued instruction frees its main-queue entry at the issuing clock edge, even when a copy is kept in the replay queue.
- R6: A wakeup with `wake_load_i`=1 opens a speculative window for its tag. A resolve whose tag differs from the open window's tag, or that arrives with no window open, is ignored.
- R7: A resolve that reports a hit (`ld_res_miss_i`=0) closes the window and discards that window's replay copies, none of which issues again.
- R8: Policy 0 (dependents only): on a miss, only the copies whose source tag equals the load tag are re-issued, with `iss_replay_o` set.
- R9: Policy 1 (whole window): on a miss, every copy taken during the window is re-issued, with `iss_replay_o` set.
- R10: Re-issues start in the cycle after the miss. They take issue ports ahead of main-queue entries, oldest first.
- R11: While a window is open and the replay queue has fewer than `ISSUE_W` free entries, no main-queue entry issues.
- R12: The value of `policy_i` is captured on the first clock edge after reset is released. Later changes to it have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | Replay policy: 0 re-issues dependents only, 1 re-issues the whole window |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | Main queue has a free entry |
| disp_id_i | input | ID_W | Instruction identifier |
| disp_src_tag_i | input | TAG_W | Producer tag of the source operand |
| disp_src_rdy_i | input | 1 | Source operand already available |
| wake_valid_i | input | 1 | Wakeup broadcast |
| wake_tag_i | input | TAG_W | Tag being woken |
| wake_load_i | input | 1 | Wakeup comes from a load (speculative) |
| ld_res_valid_i | input | 1 | Load resolution |
| ld_res_tag_i | input | TAG_W | Tag of the resolving load |
| ld_res_miss_i | input | 1 | 1 = miss, 0 = hit |
| iss_valid_o | output | ISSUE_W | Per-port issue valid |
| iss_id_o | output | ISSUE_W*ID_W | Per-port identifier, port p at bits [p*ID_W +: ID_W] |
| iss_replay_o | output | ISSUE_W | Per-port flag, 1 when the issue is a re-issue |

## Verification
The bench orders two younger entries against an older one that sits in a higher slot. A selector that ranks by slot index instead of age puts them on the wrong ports. It fills the replay queue until the stall condition holds and leaves a ready main-queue entry waiting behind it. A design without the stall, or one that does not give replays priority, lets that entry out early or out of order. It sends a resolve with a foreign tag and a hit resolve, then a window that only fits if the hit really freed its copy. A leaking or over-eager replay queue shows up as stray re-issues or delayed issues. Both policies run after separate resets, with `policy_i` flipped after the first case, so a policy decoded live or a wrong dependency test changes which copies come back.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int AGE_W = 8;
  typedef logic [AGE_W-1:0] age_t;
  typedef enum logic {POL_DEP = 1'b0, POL_WIN = 1'b1} replay_pol_e;

  // modular age compare, valid while live span < 2**(AGE_W-1)
  function automatic logic age_before(age_t a, age_t b);
    age_t d;
    d = a - b;
    return d[AGE_W-1];
  endfunction
endpackage

// File: rtl/dq_select.sv
module dq_select
  import dq_pkg::*;
#(
  parameter int REQ_N   = 12,
  parameter int ISSUE_W = 2,
  localparam int IDX_W  = $clog2(REQ_N)
) (
  input  logic [REQ_N-1:0]   req_i,
  input  logic [REQ_N-1:0]   prio_i,
  input  age_t               age_i [REQ_N],
  output logic [REQ_N-1:0]   gnt_o,
  output logic [ISSUE_W-1:0] slot_vld_o,
  output logic [IDX_W-1:0]   slot_idx_o [ISSUE_W]
);
  always_comb begin
    logic [REQ_N-1:0] left;
    logic [IDX_W-1:0] best;
    logic             found;
    left  = req_i;
    gnt_o = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      found = 1'b0;
      best  = '0;
      for (int i = 0; i < REQ_N; i++) begin
        if (left[i]) begin
          if (!found) begin
            found = 1'b1;
            best  = IDX_W'(i);
          end else if ((prio_i[i] != prio_i[best]) ? prio_i[i]
                       : age_before(age_i[i], age_i[best])) begin
            best = IDX_W'(i);
          end
        end
      end
      slot_vld_o[s] = found;
      slot_idx_o[s] = best;
      if (found) begin
        left[best]  = 1'b0;
        gnt_o[best] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dq_miq.sv
module dq_miq
  import dq_pkg::*;
#(
  parameter int MIQ_N = 8,
  parameter int ID_W  = 8,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(MIQ_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  output logic             disp_ready_o,
  input  logic [ID_W-1:0]  disp_id_i,
  input  logic [TAG_W-1:0] disp_src_tag_i,
  input  logic             disp_src_rdy_i,
  input  logic             wake_valid_i,
  input  logic [TAG_W-1:0] wake_tag_i,
  input  logic [MIQ_N-1:0] gnt_i,
  output logic [MIQ_N-1:0] req_o,
  output logic [ID_W-1:0]  id_o  [MIQ_N],
  output logic [TAG_W-1:0] src_o [MIQ_N],
  output age_t             age_o [MIQ_N]
);
  logic [MIQ_N-1:0] vld_q, rdy_q;
  logic [ID_W-1:0]  id_q  [MIQ_N];
  logic [TAG_W-1:0] src_q [MIQ_N];
  age_t             age_q [MIQ_N];
  age_t             seq_q;
  logic [IDX_W-1:0] free_idx;
  logic             has_free;

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = 0; i < MIQ_N; i++) begin
      if (!vld_q[i] && !has_free) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rdy_q <= '0;
      seq_q <= '0;
    end else begin
      for (int i = 0; i < MIQ_N; i++) begin
        if (vld_q[i]) begin
          if (gnt_i[i]) vld_q[i] <= 1'b0;
          if (wake_valid_i && src_q[i] == wake_tag_i) rdy_q[i] <= 1'b1;
        end
      end
      if (disp_valid_i && has_free) begin
        vld_q[free_idx] <= 1'b1;
        rdy_q[free_idx] <= disp_src_rdy_i || (wake_valid_i && wake_tag_i == disp_src_tag_i);
        id_q[free_idx]  <= disp_id_i;
        src_q[free_idx] <= disp_src_tag_i;
        age_q[free_idx] <= seq_q;
        seq_q           <= seq_q + 1'b1;
      end
    end
  end

  assign disp_ready_o = has_free;
  assign req_o        = vld_q & rdy_q;
  assign id_o         = id_q;
  assign src_o        = src_q;
  assign age_o        = age_q;
endmodule

// File: rtl/dq_riq.sv
module dq_riq
  import dq_pkg::*;
#(
  parameter int RIQ_N   = 4,
  parameter int ISSUE_W = 2,
  parameter int ID_W    = 8,
  parameter int TAG_W   = 4,
  localparam int IDX_W  = $clog2(RIQ_N),
  localparam int CNT_W  = $clog2(RIQ_N + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  replay_pol_e        pol_i,
  input  logic [ISSUE_W-1:0] alloc_vld_i,
  input  logic [ID_W-1:0]    alloc_id_i  [ISSUE_W],
  input  logic [ISSUE_W-1:0] alloc_dep_i,
  input  age_t               alloc_age_i [ISSUE_W],
  input  logic [TAG_W-1:0]   alloc_tag_i,
  input  logic               res_fire_i,
  input  logic [TAG_W-1:0]   res_tag_i,
  input  logic               res_miss_i,
  input  logic [RIQ_N-1:0]   gnt_i,
  output logic [RIQ_N-1:0]   req_o,
  output logic [ID_W-1:0]    id_o  [RIQ_N],
  output age_t               age_o [RIQ_N],
  output logic [CNT_W-1:0]   free_o
);
  logic [RIQ_N-1:0]   vld_q, pend_q, dep_q;
  logic [ID_W-1:0]    id_q  [RIQ_N];
  logic [TAG_W-1:0]   tag_q [RIQ_N];
  age_t               age_q [RIQ_N];
  logic [IDX_W-1:0]   sel_idx [ISSUE_W];
  logic [ISSUE_W-1:0] sel_ok;

  always_comb begin
    logic [RIQ_N-1:0] taken;
    taken = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      sel_idx[s] = '0;
      sel_ok[s]  = 1'b0;
      for (int i = 0; i < RIQ_N; i++) begin
        if (!vld_q[i] && !taken[i] && !sel_ok[s]) begin
          sel_idx[s] = IDX_W'(i);
          sel_ok[s]  = 1'b1;
          taken[i]   = 1'b1;
        end
      end
    end
    free_o = '0;
    for (int i = 0; i < RIQ_N; i++) free_o = free_o + CNT_W'(!vld_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      pend_q <= '0;
      dep_q  <= '0;
    end else begin
      for (int i = 0; i < RIQ_N; i++) begin
        if (vld_q[i]) begin
          if (gnt_i[i]) vld_q[i] <= 1'b0;
          else if (res_fire_i && !pend_q[i] && tag_q[i] == res_tag_i) begin
            if (res_miss_i && (pol_i == POL_WIN || dep_q[i])) pend_q[i] <= 1'b1;
            else vld_q[i] <= 1'b0;
          end
        end
      end
      // copy taken in the resolving cycle is settled on arrival
      for (int s = 0; s < ISSUE_W; s++) begin
        if (alloc_vld_i[s] && sel_ok[s] &&
            (!res_fire_i || (res_miss_i && (pol_i == POL_WIN || alloc_dep_i[s])))) begin
          vld_q[sel_idx[s]]  <= 1'b1;
          pend_q[sel_idx[s]] <= res_fire_i;
          dep_q[sel_idx[s]]  <= alloc_dep_i[s];
          id_q[sel_idx[s]]   <= alloc_id_i[s];
          tag_q[sel_idx[s]]  <= alloc_tag_i;
          age_q[sel_idx[s]]  <= alloc_age_i[s];
        end
      end
    end
  end

  assign req_o = vld_q & pend_q;
  assign id_o  = id_q;
  assign age_o = age_q;
endmodule

// File: rtl/dual_issue_queue.sv
module dual_issue_queue
  import dq_pkg::*;
#(
  parameter int MIQ_N   = 8,
  parameter int RIQ_N   = 4,
  parameter int ISSUE_W = 2,
  parameter int ID_W    = 8,
  parameter int TAG_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    policy_i,
  input  logic                    disp_valid_i,
  output logic                    disp_ready_o,
  input  logic [ID_W-1:0]         disp_id_i,
  input  logic [TAG_W-1:0]        disp_src_tag_i,
  input  logic                    disp_src_rdy_i,
  input  logic                    wake_valid_i,
  input  logic [TAG_W-1:0]        wake_tag_i,
  input  logic                    wake_load_i,
  input  logic                    ld_res_valid_i,
  input  logic [TAG_W-1:0]        ld_res_tag_i,
  input  logic                    ld_res_miss_i,
  output logic [ISSUE_W-1:0]      iss_valid_o,
  output logic [ISSUE_W*ID_W-1:0] iss_id_o,
  output logic [ISSUE_W-1:0]      iss_replay_o
);
  localparam int REQ_N = RIQ_N + MIQ_N;
  localparam int IDX_W = $clog2(REQ_N);
  localparam int CNT_W = $clog2(RIQ_N + 1);

  replay_pol_e      pol_q;
  logic             cfg_q, win_q, res_fire, stall;
  logic [TAG_W-1:0] win_tag_q;
  logic [CNT_W-1:0] riq_free;

  logic [MIQ_N-1:0] miq_req, miq_gnt;
  logic [ID_W-1:0]  miq_id  [MIQ_N];
  logic [TAG_W-1:0] miq_src [MIQ_N];
  age_t             miq_age [MIQ_N];
  logic [RIQ_N-1:0] riq_req, riq_gnt;
  logic [ID_W-1:0]  riq_id  [RIQ_N];
  age_t             riq_age [RIQ_N];

  logic [REQ_N-1:0] all_req, all_prio, all_gnt;
  logic [ID_W-1:0]  all_id  [REQ_N];
  logic [TAG_W-1:0] all_src [REQ_N];
  age_t             all_age [REQ_N];

  logic [ISSUE_W-1:0] slot_vld, alloc_vld, alloc_dep;
  logic [IDX_W-1:0]   slot_idx  [ISSUE_W];
  logic [ID_W-1:0]    alloc_id  [ISSUE_W];
  age_t               alloc_age [ISSUE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= 1'b0;
      pol_q     <= POL_DEP;
      win_q     <= 1'b0;
      win_tag_q <= '0;
    end else begin
      if (!cfg_q) begin
        cfg_q <= 1'b1;
        pol_q <= replay_pol_e'(policy_i);
      end
      if (wake_valid_i && wake_load_i) begin
        win_q     <= 1'b1;
        win_tag_q <= wake_tag_i;
      end else if (res_fire) begin
        win_q <= 1'b0;
      end
    end
  end

  assign res_fire = ld_res_valid_i && win_q && (ld_res_tag_i == win_tag_q);
  assign stall    = win_q && (int'(riq_free) < ISSUE_W);

  dq_miq #(.MIQ_N(MIQ_N), .ID_W(ID_W), .TAG_W(TAG_W)) u_miq (
    .clk_i, .rst_ni, .disp_valid_i, .disp_ready_o, .disp_id_i, .disp_src_tag_i,
    .disp_src_rdy_i, .wake_valid_i, .wake_tag_i, .gnt_i(miq_gnt), .req_o(miq_req),
    .id_o(miq_id), .src_o(miq_src), .age_o(miq_age)
  );

  dq_riq #(.RIQ_N(RIQ_N), .ISSUE_W(ISSUE_W), .ID_W(ID_W), .TAG_W(TAG_W)) u_riq (
    .clk_i, .rst_ni, .pol_i(pol_q), .alloc_vld_i(alloc_vld), .alloc_id_i(alloc_id),
    .alloc_dep_i(alloc_dep), .alloc_age_i(alloc_age), .alloc_tag_i(win_tag_q),
    .res_fire_i(res_fire), .res_tag_i(ld_res_tag_i), .res_miss_i(ld_res_miss_i),
    .gnt_i(riq_gnt), .req_o(riq_req), .id_o(riq_id), .age_o(riq_age), .free_o(riq_free)
  );

  // replay entries occupy the low indices of the joint request vector
  for (genvar i = 0; i < RIQ_N; i++) begin : g_rmap
    assign all_id[i]  = riq_id[i];
    assign all_age[i] = riq_age[i];
    assign all_src[i] = '0;
  end
  for (genvar j = 0; j < MIQ_N; j++) begin : g_mmap
    assign all_id[RIQ_N+j]  = miq_id[j];
    assign all_age[RIQ_N+j] = miq_age[j];
    assign all_src[RIQ_N+j] = miq_src[j];
  end

  assign all_req  = {miq_req & {MIQ_N{~stall}}, riq_req};
  assign all_prio = {{MIQ_N{1'b0}}, {RIQ_N{1'b1}}};
  assign riq_gnt  = all_gnt[RIQ_N-1:0];
  assign miq_gnt  = all_gnt[REQ_N-1:RIQ_N];

  dq_select #(.REQ_N(REQ_N), .ISSUE_W(ISSUE_W)) u_sel (
    .req_i(all_req), .prio_i(all_prio), .age_i(all_age),
    .gnt_o(all_gnt), .slot_vld_o(slot_vld), .slot_idx_o(slot_idx)
  );

  always_comb begin
    for (int s = 0; s < ISSUE_W; s++) begin
      logic is_rep;
      is_rep                    = int'(slot_idx[s]) < RIQ_N;
      iss_valid_o[s]            = slot_vld[s];
      iss_replay_o[s]           = slot_vld[s] && is_rep;
      iss_id_o[s*ID_W +: ID_W]  = all_id[slot_idx[s]];
      alloc_vld[s]              = slot_vld[s] && !is_rep && win_q;
      alloc_id[s]               = all_id[slot_idx[s]];
      alloc_age[s]              = all_age[slot_idx[s]];
      alloc_dep[s]              = all_src[slot_idx[s]] == win_tag_q;
    end
  end
endmodule

// File: rtl/dq_chk.sv
module dq_chk #(
  parameter int ISSUE_W = 2,
  parameter int CNT_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ISSUE_W-1:0] iss_valid_o,
  input logic [ISSUE_W-1:0] iss_replay_o,
  input logic               win_q,
  input logic [CNT_W-1:0]   riq_free,
  input logic               res_fire,
  input logic               wake_valid_i,
  input logic               wake_load_i,
  input logic               cfg_q,
  input logic               pol_q
);
  AST_SLOTS_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((iss_valid_o & (iss_valid_o + ISSUE_W'(1))) == '0)); // R4

  for (genvar s = 1; s < ISSUE_W; s++) begin : g_ord
    AST_REPLAY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_o[s] && iss_replay_o[s]) |-> iss_replay_o[s-1]); // R10
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && int'(riq_free) < ISSUE_W) |-> ((iss_valid_o & ~iss_replay_o) == '0)); // R11

  AST_WIN_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_fire && !(wake_valid_i && wake_load_i)) |=> !win_q); // R6

  AST_POLICY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && $past(cfg_q)) |-> $stable(pol_q)); // R12
endmodule

bind dual_issue_queue dq_chk #(.ISSUE_W(ISSUE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .iss_valid_o(iss_valid_o), .iss_replay_o(iss_replay_o),
  .win_q(win_q), .riq_free(riq_free), .res_fire(res_fire), .wake_valid_i(wake_valid_i),
  .wake_load_i(wake_load_i), .cfg_q(cfg_q), .pol_q(pol_q)
);

// File: tb/sim_dual_issue_queue.sv
module sim_dual_issue_queue;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2, ID_W = 8, TAG_W = 4, MIQ_N = 8;

  logic clk = 1'b0, rst_n = 1'b0, policy = 1'b0;
  logic disp_valid = 1'b0, disp_src_rdy = 1'b0, disp_ready;
  logic [ID_W-1:0] disp_id = '0;
  logic [TAG_W-1:0] disp_tag = '0, wake_tag = '0, res_tag = '0;
  logic wake_valid = 1'b0, wake_load = 1'b0, res_valid = 1'b0, res_miss = 1'b0;
  logic [W-1:0] iss_valid, iss_replay;
  logic [W*ID_W-1:0] iss_id;

  int n_chk = 0, n_bad = 0;
  int exp_id[$];
  bit exp_rep[$];
  string exp_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_queue #(.MIQ_N(MIQ_N), .RIQ_N(4), .ISSUE_W(W), .ID_W(ID_W), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .disp_valid_i(disp_valid),
    .disp_ready_o(disp_ready), .disp_id_i(disp_id), .disp_src_tag_i(disp_tag),
    .disp_src_rdy_i(disp_src_rdy), .wake_valid_i(wake_valid), .wake_tag_i(wake_tag),
    .wake_load_i(wake_load), .ld_res_valid_i(res_valid), .ld_res_tag_i(res_tag),
    .ld_res_miss_i(res_miss), .iss_valid_o(iss_valid), .iss_id_o(iss_id),
    .iss_replay_o(iss_replay)
  );

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic expect_iss(int id, bit rep, string rq);
    exp_id.push_back(id);
    exp_rep.push_back(rep);
    exp_req.push_back(rq);
  endtask

  // monitor: ports are compared in order, value = id*2 + replay flag
  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < W; s++) begin
        if (iss_valid[s]) begin
          int act;
          act = int'(iss_id[s*ID_W +: ID_W]) * 2 + int'(iss_replay[s]);
          if (exp_id.size() == 0) chk(1'b0, "R4", "unexpected issue id*2+rep", act, -1);
          else begin
            int e;
            string rq;
            e  = exp_id.pop_front() * 2 + int'(exp_rep.pop_front());
            rq = exp_req.pop_front();
            chk(act == e, rq, "issue id*2+rep", act, e);
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic dispatch(int id, int tag, bit rdy);
    disp_valid = 1'b1; disp_id = ID_W'(id); disp_tag = TAG_W'(tag); disp_src_rdy = rdy;
    step();
    disp_valid = 1'b0; disp_src_rdy = 1'b0;
  endtask

  task automatic wake(int tag, bit ld);
    wake_valid = 1'b1; wake_tag = TAG_W'(tag); wake_load = ld;
    step();
    wake_valid = 1'b0; wake_load = 1'b0;
  endtask

  task automatic resolve(int tag, bit miss);
    res_valid = 1'b1; res_tag = TAG_W'(tag); res_miss = miss;
    step();
    res_valid = 1'b0; res_miss = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic do_reset(bit pol);
    rst_n = 1'b0; policy = pol;
    idle(3);
    @(negedge clk);
    chk(disp_ready == 1'b1, "R1", "disp_ready in reset", int'(disp_ready), 1);
    chk(iss_valid == '0, "R1", "iss_valid in reset", int'(iss_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);

    // R3 ready at dispatch, R4 age beats slot index
    expect_iss(10, 0, "R3");
    dispatch(10, 0, 1);
    dispatch(11, 2, 0);
    dispatch(12, 2, 0);
    expect_iss(11, 0, "R4");
    expect_iss(12, 0, "R3");
    wake(2, 0);
    idle(3);

    // R2 full main queue, dropped dispatch, R4 two per cycle
    for (int k = 0; k < MIQ_N; k++) dispatch(60 + k, 3, 0);
    @(negedge clk);
    chk(disp_ready == 1'b0, "R2", "disp_ready when full", int'(disp_ready), 0);
    @(posedge clk); #1;
    dispatch(99, 3, 0);
    for (int k = 0; k < MIQ_N; k++) expect_iss(60 + k, 0, "R4");
    wake(3, 0);
    idle(6);
    @(negedge clk);
    chk(disp_ready == 1'b1, "R2", "disp_ready after drain", int'(disp_ready), 1);
    @(posedge clk); #1;

    // policy 0: R6 window, R11 stall, R8 dependents only, R10 replay first
    dispatch(30, 5, 0);
    dispatch(31, 5, 0);
    dispatch(32, 1, 0);
    expect_iss(30, 0, "R6");
    expect_iss(31, 0, "R6");
    wake(5, 1);
    expect_iss(32, 0, "R3");
    wake(1, 0);
    dispatch(33, 0, 1);
    idle(4);
    expect_iss(30, 1, "R8");
    expect_iss(31, 1, "R10");
    expect_iss(33, 0, "R11");
    resolve(5, 1);
    idle(4);

    // R7 hit drops the copy
    expect_iss(40, 0, "R7");
    dispatch(40, 6, 0);
    wake(6, 1);
    idle(2);
    resolve(6, 0);
    idle(4);

    // R7 freed space lets four copies fit, R6 foreign resolve ignored
    dispatch(41, 7, 0);
    dispatch(45, 7, 0);
    dispatch(46, 7, 0);
    dispatch(47, 7, 0);
    expect_iss(41, 0, "R7");
    expect_iss(45, 0, "R7");
    expect_iss(46, 0, "R7");
    expect_iss(47, 0, "R7");
    wake(7, 1);
    idle(3);
    resolve(9, 1);
    idle(3);
    expect_iss(41, 1, "R6");
    expect_iss(45, 1, "R8");
    expect_iss(46, 1, "R8");
    expect_iss(47, 1, "R8");
    resolve(7, 1);
    idle(4);
    chk(exp_id.size() == 0, "R8", "pending expectations", exp_id.size(), 0);

    // policy 1, latched at reset then input flipped: R9, R12, R5
    do_reset(1'b1);
    policy = 1'b0;
    dispatch(50, 5, 0);
    dispatch(51, 1, 0);
    expect_iss(50, 0, "R6");
    wake(5, 1);
    expect_iss(51, 0, "R3");
    wake(1, 0);
    idle(2);
    for (int k = 0; k < MIQ_N - 1; k++) dispatch(70 + k, 4, 0);
    @(negedge clk);
    chk(disp_ready == 1'b1, "R5", "disp_ready with one entry left", int'(disp_ready), 1);
    @(posedge clk); #1;
    dispatch(77, 4, 0);
    @(negedge clk);
    chk(disp_ready == 1'b0, "R5", "disp_ready when refilled", int'(disp_ready), 0);
    @(posedge clk); #1;
    expect_iss(50, 1, "R12");
    expect_iss(51, 1, "R9");
    resolve(5, 1);
    idle(2);
    for (int k = 0; k < MIQ_N; k++) expect_iss(70 + k, 0, "R4");
    wake(4, 0);
    idle(8);

    chk(exp_id.size() == 0, "R9", "pending expectations", exp_id.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule